// File: doc/BRIEF.md
# Glitch-free two-clock switch

This block picks one of two unrelated clocks and forwards it on a single output, using a select input to choose the source. Each source has its own gate. A gate's enable flop is clocked on the falling edge of that same source. Each enable flop also takes the other branch's enable as a blocking term. When the selection changes, the branch that is on shuts first, on its own falling edge. The other branch turns on only after that, on a falling edge of its own clock. The output therefore never carries a shortened pulse, and it never carries two pulses joined together.

The block sits in front of a clock tree wherever a domain must move between two sources while running. The select input may change at any time relative to either clock. The interlock supplies ordering only. It does not resynchronize the select input beyond the two enable flops.

Top module: `clk_switch`

## Requirements
- R1: While rst_ni is low, both branch enables are cleared at once and clk_o stays low.
- R2: Branch 0 turns on at a falling edge of clk0_i at which sel_i is 0 and branch 1 is off. From the next rising edge of clk0_i, clk_o follows clk0_i.
- R3: Branch 1 turns on at a falling edge of clk1_i at which sel_i is 1 and branch 0 is off. From the next rising edge of clk1_i, clk_o follows clk1_i.
- R4: The two branch enables are never high together. clk_o never shows a pulse formed from both sources.
- R5: A branch enable changes only at a falling edge of its own clock. A sel_i change that is undone before that edge has no effect on clk_o.
- R6: While a branch is on, clk_o equals that branch's clock. Every high pulse on clk_o lasts exactly the high phase of the clock that was selected at its rising edge.
- R7: When neither branch is on, as between the old branch's shut-off edge and the new branch's turn-on edge, clk_o is low.
- R8: If sel_i returns to the old value after the old branch has shut off but before the new branch has turned on, the old branch turns on again at its next falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0_i | input | 1 | Source clock for branch 0 |
| clk1_i | input | 1 | Source clock for branch 1 |
| sel_i | input | 1 | Source select: 0 picks clk0_i, 1 picks clk1_i |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_o | output | 1 | Switched output clock |

## Verification
The hardest case to reach is a select reversal that lands inside a handover. It must arrive after the old branch has shut off and before the other branch's falling edge. The bench reaches it by driving sel_i a quarter nanosecond after a falling edge of clk1_i and reversing it right after the next one. The clock periods are chosen so that no edges of the two clocks coincide. Many further select changes are spaced by random whole-nanosecond gaps. A behavioural model tracks which source should be live. The output is compared against that model every half nanosecond, and the width of every output pulse is measured.

// File: rtl/clk_switch_pkg.sv
package clk_switch_pkg;
  localparam int unsigned NUM_SRC = 2;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/clk_switch_branch.sv
module clk_switch_branch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic block_i,
  output logic en_o,
  output logic gclk_o
);
  // enable moves only while clk_i is low, so gclk_o pulses are whole or absent
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= 1'b0;
    else         en_o <= want_i & ~block_i;
  end

  assign gclk_o = clk_i & en_o;
endmodule

// File: rtl/clk_switch_merge.sv
module clk_switch_merge #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] gclk_i,
  output logic         clk_o
);
  assign clk_o = |gclk_i;
endmodule

// File: rtl/clk_switch.sv
module clk_switch
  import clk_switch_pkg::*;
(
  input  logic clk0_i,
  input  logic clk1_i,
  input  logic sel_i,
  input  logic rst_ni,
  output logic clk_o
);
  src_vec_t src_clk;
  src_vec_t want;
  src_vec_t en_q;
  src_vec_t gclk;

  assign src_clk = {clk1_i, clk0_i};
  assign want    = {sel_i, ~sel_i};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_br
    clk_switch_branch u_br (
      .clk_i  (src_clk[g]),
      .rst_ni (rst_ni),
      .want_i (want[g]),
      .block_i(|(en_q & ~(src_vec_t'(1) << g))),
      .en_o   (en_q[g]),
      .gclk_o (gclk[g])
    );
  end

  clk_switch_merge #(.N(NUM_SRC)) u_merge (
    .gclk_i(gclk),
    .clk_o (clk_o)
  );
endmodule

// File: rtl/clk_switch_chk.sv
module clk_switch_chk (
  input logic       clk0_i,
  input logic       clk1_i,
  input logic       sel_i,
  input logic       rst_ni,
  input logic [1:0] en_i,
  input logic       clk_o
);
  assert_excl_c0_R4: assert property (@(posedge clk0_i) disable iff (!rst_ni)
    !(en_i[0] && en_i[1]));
  assert_excl_c1_R4: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    !(en_i[0] && en_i[1]));

  assert_up0_R2: assert property (@(negedge clk0_i) disable iff (!rst_ni)
    (!sel_i && !en_i[1]) |=> en_i[0]);
  assert_up1_R3: assert property (@(negedge clk1_i) disable iff (!rst_ni)
    (sel_i && !en_i[0]) |=> en_i[1]);

  assert_gate0_R6: assert property (@(negedge clk0_i) disable iff (!rst_ni)
    en_i[0] |-> clk_o);
  assert_gate1_R6: assert property (@(negedge clk1_i) disable iff (!rst_ni)
    en_i[1] |-> clk_o);

  assert_gap_R7: assert property (@(negedge clk0_i) disable iff (!rst_ni)
    (en_i == 2'b00) |-> !clk_o);

  always @(posedge en_i[0] or negedge en_i[0])
    if (rst_ni === 1'b1) assert_edge0_R5: assert (clk0_i == 1'b0);
  always @(posedge en_i[1] or negedge en_i[1])
    if (rst_ni === 1'b1) assert_edge1_R5: assert (clk1_i == 1'b0);
endmodule

bind clk_switch clk_switch_chk u_chk (
  .clk0_i(clk0_i),
  .clk1_i(clk1_i),
  .sel_i (sel_i),
  .rst_ni(rst_ni),
  .en_i  (en_q),
  .clk_o (clk_o)
);

// File: tb/clk_switch_bench.sv
`timescale 1ns/10ps
module clk_switch_bench;
  localparam real CLK_PERIOD = 10.0;
  localparam real CLK1_HALF  = 7.0;
  localparam int  HI0_CP     = 500;  // clk0 high time, 10 ps units
  localparam int  HI1_CP     = 700;

  logic clk0, clk1, sel, rst_n, clk_out;
  int   n_chk = 0, n_fail = 0;
  int   active = -1;          // model: live source, -1 = none
  bit   done = 0;

  clk_switch u_clk_switch (
    .clk0_i(clk0), .clk1_i(clk1), .sel_i(sel), .rst_ni(rst_n), .clk_o(clk_out)
  );

  initial begin clk0 = 0; forever #(CLK_PERIOD/2) clk0 = ~clk0; end
  initial begin clk1 = 0; #0.5; forever #(CLK1_HALF) clk1 = ~clk1; end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // behavioural model of the live source
  always @(negedge rst_n) active = -1;
  always @(negedge clk0) if (rst_n) begin
    if (active == 0 && sel) active = -1;
    else if (active == -1 && !sel) active = 0;
  end
  always @(negedge clk1) if (rst_n) begin
    if (active == 1 && !sel) active = -1;
    else if (active == -1 && sel) active = 1;
  end

  // sampled compare, off every clock edge
  initial begin
    #0.25;
    while (!done) begin
      bit exp;
      string tag;
      exp = (active == 0 && clk0) || (active == 1 && clk1);
      tag = !rst_n ? "R1" : (active == -1 ? "R7" : "R6");
      check(clk_out === exp, tag, int'(clk_out), int'(exp));
      #0.5;
    end
  end

  // pulse width
  real t_rise;
  int  rise_src = -2;
  always @(negedge rst_n) rise_src = -2;
  always @(posedge clk_out) begin t_rise = $realtime; rise_src = active; end
  always @(negedge clk_out) if (rst_n && rise_src >= 0) begin
    int w;
    int e;
    w = int'(($realtime - t_rise) * 100.0);
    e = (rise_src == 0) ? HI0_CP : HI1_CP;
    check(w == e, "R4 R6 pulse width", w, e);
    rise_src = -2;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; sel = 0;
    #11.25;
    check(clk_out === 1'b0, "R1 reset output", int'(clk_out), 0);
    #12;
    rst_n = 1;
    // R2: first clk0 falling edge turns branch 0 on
    @(negedge clk0); @(posedge clk0); #0.25;
    check(clk_out === 1'b1, "R2 branch0 up", int'(clk_out), 1);

    // R5: short select blip between clk0 falling edges
    @(negedge clk0); #1.25; sel = 1; #1; sel = 0;
    @(posedge clk0); #0.25;
    check(clk_out === 1'b1, "R5 blip ignored", int'(clk_out), 1);

    // R3: switch to clk1
    #3; sel = 1;
    #60;
    @(posedge clk1); #0.25;
    check(clk_out === 1'b1, "R3 branch1 up", int'(clk_out), 1);

    // R8: reverse select inside the handover
    @(negedge clk1); #0.25; sel = 0;
    @(negedge clk1); #0.25; sel = 1;
    #40;
    @(posedge clk1); #0.25;
    check(clk_out === 1'b1, "R8 branch1 back", int'(clk_out), 1);
    @(negedge clk1); #0.25;
    check(clk_out === 1'b0, "R8 low phase", int'(clk_out), 0);

    // R1: reset mid-run, then branch 1 comes up with sel high
    #3; rst_n = 0; #0.5;
    check(clk_out === 1'b0, "R1 reset mid-run", int'(clk_out), 0);
    #20; rst_n = 1;
    @(negedge clk1); @(posedge clk1); #0.25;
    check(clk_out === 1'b1, "R3 after reset", int'(clk_out), 1);

    // random select traffic
    for (int i = 0; i < 300; i++) begin
      #($urandom_range(1, 60));
      sel = ~sel;
    end
    #80;
    done = 1;
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule